// File: doc/BRIEF.md
# Debug Address Comparator Bank

This block sits inside a processor core next to the fetch and load/store stages. It holds a bank of instruction-address comparators and a bank of data-address comparators. Each cycle it compares the fetch program counter against every armed instruction comparator. It also compares the address of any load or store against every armed data comparator, and each data comparator applies its own access-type qualifier. When any comparator fires, the block raises a debug exception in the same cycle. The core can then halt before the matching instruction retires or the matching access commits.

Software programs the block through a small word-addressed register port. A read-only capability word reports how many comparators of each kind were built, so firmware can size its use of them. A sticky status word records which comparators have fired since it was last cleared, and each bit is cleared by writing 1 to it. While the core is already in debug mode, matches neither raise the exception nor update the status.

Register layout, as a 5-bit word address: 0x00 capability, 0x01 instruction-comparator enable mask, 0x02 data-comparator enable mask, 0x03 hit status. The ranges 0x08+i, 0x10+i and 0x18+i hold, for comparator i (0 to 7), the instruction compare address, the data compare address and the data access condition.

Top module: `dbg_match_unit`

## Requirements
- R1: The word at address 0x00 reads NUM_PC in bits [3:0] and NUM_DA in bits [7:4], with all other bits zero.
- R2: After reset, every enable mask, compare address, condition and status bit is zero, and no exception is raised even when a fetch address equals a reset compare value.
- R3: An instruction comparator fires when fetch_valid is high, its enable bit (address 0x01, bit i) is set, and fetch_pc equals its compare address exactly. A neighbouring address does not fire it.
- R4: A comparator whose enable bit is clear never fires, whatever its compare address.
- R5: Data comparators consider only cycles with mem_valid high. A fetch address never fires them.
- R6: The 2-bit data condition (address 0x18+i, bits [1:0]) means 01 = loads only, 10 = stores only, 11 = loads and stores, 00 = never. mem_is_store = 1 marks a store and 0 marks a load.
- R7: dbg_exc and the per-comparator hit vectors are combinational, valid in the same cycle as the matching fetch or access.
- R8: A hit sets its status bit (address 0x03: instruction comparator i at bit i, data comparator j at bit 8+j) at the next clock edge. The bit then stays set.
- R9: Writing address 0x03 clears exactly the status bits written as 1. A hit in the same cycle as the clear leaves its bit set.
- R10: When several comparators fire in one cycle, one dbg_exc is raised and all of their status bits are set together.
- R11: While in_debug is high, dbg_exc stays low and the status bits do not change.
- R12: Writes to comparator slots at or above the built count are ignored, and those slots read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| fetch_valid | input | 1 | Fetch PC is valid this cycle |
| fetch_pc | input | AW | Fetch program counter |
| mem_valid | input | 1 | A load or store is presented this cycle |
| mem_is_store | input | 1 | 1 = store, 0 = load |
| mem_addr | input | AW | Load/store effective address |
| in_debug | input | 1 | Core is already in debug mode |
| dbg_exc | output | 1 | Debug exception request |
| pc_hit | output | NUM_PC | Instruction comparators firing this cycle |
| da_hit | output | NUM_DA | Data comparators firing this cycle |
| pc_sticky | output | NUM_PC | Sticky status, instruction comparators |
| da_sticky | output | NUM_DA | Sticky status, data comparators |

## Verification
The exception and the hit vectors are due in the cycle in which the fetch or access is presented. The bench drives them at the falling edge and samples them one time unit later, before any rising edge. Register writes and sticky-status updates are due one rising edge later. The bench therefore reads the status only after that edge, through the combinational read port, and before it presents the next stimulus. The set-wins-over-clear case drives the write strobe and a matching fetch in the same cycle and reads the status afterwards.

// File: rtl/dbg_match_pkg.sv
package dbg_match_pkg;

  localparam int unsigned REG_AW = 5;
  localparam int unsigned REG_DW = 32;

  // Top-level register word addresses
  localparam logic [REG_AW-1:0] A_CAP    = 5'h00;
  localparam logic [REG_AW-1:0] A_PC_EN  = 5'h01;
  localparam logic [REG_AW-1:0] A_DA_EN  = 5'h02;
  localparam logic [REG_AW-1:0] A_STATUS = 5'h03;

  // Upper two address bits select a per-comparator bank
  typedef enum logic [1:0] {
    BANK_CTRL = 2'b00,
    BANK_PCA  = 2'b01,
    BANK_DAA  = 2'b10,
    BANK_DCND = 2'b11
  } bank_e;

  // Access qualifier: bit0 admits loads, bit1 admits stores
  typedef logic [1:0] dcond_t;

  function automatic logic cond_admits(dcond_t c, logic is_store);
    return is_store ? c[1] : c[0];
  endfunction

  function automatic logic [REG_DW-1:0] cap_word(int unsigned npc, int unsigned nda);
    logic [REG_DW-1:0] w;
    w = '0;
    w[3:0] = 4'(npc);
    w[7:4] = 4'(nda);
    return w;
  endfunction

endpackage

// File: rtl/dbg_pc_cmp.sv
module dbg_pc_cmp #(
  parameter int unsigned N  = 4,
  parameter int unsigned AW = 32
) (
  input  logic          valid,
  input  logic [AW-1:0] pc,
  input  logic [N-1:0]  en,
  input  logic [AW-1:0] cmp_addr [N],
  output logic [N-1:0]  hit
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit[i] = valid && en[i] && (pc == cmp_addr[i]);
  end
endmodule

// File: rtl/dbg_data_cmp.sv
module dbg_data_cmp
  import dbg_match_pkg::*;
#(
  parameter int unsigned N  = 4,
  parameter int unsigned AW = 32
) (
  input  logic          valid,
  input  logic          is_store,
  input  logic [AW-1:0] addr,
  input  logic [N-1:0]  en,
  input  logic [AW-1:0] cmp_addr [N],
  input  dcond_t        cond [N],
  output logic [N-1:0]  hit
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit[i] = valid && en[i] && cond_admits(cond[i], is_store)
                    && (addr == cmp_addr[i]);
  end
endmodule

// File: rtl/dbg_hit_log.sv
module dbg_hit_log #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic [N-1:0] clr_vec,
  input  logic         freeze,
  output logic [N-1:0] q
);
  logic [N-1:0] set_eff;
  assign set_eff = freeze ? '0 : set_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr_vec) | set_eff;
  end
endmodule

// File: rtl/dbg_match_unit.sv
module dbg_match_unit
  import dbg_match_pkg::*;
#(
  parameter int unsigned NUM_PC = 4,
  parameter int unsigned NUM_DA = 4,
  parameter int unsigned AW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [4:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              fetch_valid,
  input  logic [AW-1:0]     fetch_pc,
  input  logic              mem_valid,
  input  logic              mem_is_store,
  input  logic [AW-1:0]     mem_addr,
  input  logic              in_debug,
  output logic              dbg_exc,
  output logic [NUM_PC-1:0] pc_hit,
  output logic [NUM_DA-1:0] da_hit,
  output logic [NUM_PC-1:0] pc_sticky,
  output logic [NUM_DA-1:0] da_sticky
);
  localparam int unsigned DA_SHIFT = 8;

  logic [NUM_PC-1:0] pc_en_q;
  logic [NUM_DA-1:0] da_en_q;
  logic [AW-1:0]     pc_addr_q [NUM_PC];
  logic [AW-1:0]     da_addr_q [NUM_DA];
  dcond_t            da_cond_q [NUM_DA];

  bank_e             bank;
  logic [2:0]        slot;
  logic              status_wr;
  logic [NUM_PC-1:0] pc_clr;
  logic [NUM_DA-1:0] da_clr;
  logic              any_hit;

  assign bank      = bank_e'(reg_addr[4:3]);
  assign slot      = reg_addr[2:0];
  assign status_wr = reg_we && (reg_addr == A_STATUS);
  assign pc_clr    = status_wr ? reg_wdata[NUM_PC-1:0] : '0;
  assign da_clr    = status_wr ? reg_wdata[DA_SHIFT +: NUM_DA] : '0;

  // Configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_en_q <= '0;
      da_en_q <= '0;
      for (int i = 0; i < NUM_PC; i++) pc_addr_q[i] <= '0;
      for (int i = 0; i < NUM_DA; i++) begin
        da_addr_q[i] <= '0;
        da_cond_q[i] <= 2'b00;
      end
    end else if (reg_we) begin
      if (reg_addr == A_PC_EN) pc_en_q <= reg_wdata[NUM_PC-1:0];
      if (reg_addr == A_DA_EN) da_en_q <= reg_wdata[NUM_DA-1:0];
      for (int i = 0; i < NUM_PC; i++)
        if (bank == BANK_PCA && slot == 3'(i)) pc_addr_q[i] <= reg_wdata[AW-1:0];
      for (int i = 0; i < NUM_DA; i++) begin
        if (bank == BANK_DAA && slot == 3'(i))  da_addr_q[i] <= reg_wdata[AW-1:0];
        if (bank == BANK_DCND && slot == 3'(i)) da_cond_q[i] <= reg_wdata[1:0];
      end
    end
  end

  // Register read path
  always_comb begin
    reg_rdata = '0;
    unique case (bank)
      BANK_CTRL: begin
        case (reg_addr)
          A_CAP:    reg_rdata = cap_word(NUM_PC, NUM_DA);
          A_PC_EN:  reg_rdata[NUM_PC-1:0] = pc_en_q;
          A_DA_EN:  reg_rdata[NUM_DA-1:0] = da_en_q;
          A_STATUS: begin
            reg_rdata[NUM_PC-1:0]          = pc_sticky;
            reg_rdata[DA_SHIFT +: NUM_DA]  = da_sticky;
          end
          default:  reg_rdata = '0;
        endcase
      end
      BANK_PCA:
        for (int i = 0; i < NUM_PC; i++)
          if (slot == 3'(i)) reg_rdata[AW-1:0] = pc_addr_q[i];
      BANK_DAA:
        for (int i = 0; i < NUM_DA; i++)
          if (slot == 3'(i)) reg_rdata[AW-1:0] = da_addr_q[i];
      BANK_DCND:
        for (int i = 0; i < NUM_DA; i++)
          if (slot == 3'(i)) reg_rdata[1:0] = da_cond_q[i];
      default: reg_rdata = '0;
    endcase
  end

  dbg_pc_cmp #(.N(NUM_PC), .AW(AW)) u_pc_cmp (
    .valid    (fetch_valid),
    .pc       (fetch_pc),
    .en       (pc_en_q),
    .cmp_addr (pc_addr_q),
    .hit      (pc_hit)
  );

  dbg_data_cmp #(.N(NUM_DA), .AW(AW)) u_da_cmp (
    .valid    (mem_valid),
    .is_store (mem_is_store),
    .addr     (mem_addr),
    .en       (da_en_q),
    .cmp_addr (da_addr_q),
    .cond     (da_cond_q),
    .hit      (da_hit)
  );

  dbg_hit_log #(.N(NUM_PC)) u_pc_log (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (pc_hit),
    .clr_vec (pc_clr),
    .freeze  (in_debug),
    .q       (pc_sticky)
  );

  dbg_hit_log #(.N(NUM_DA)) u_da_log (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (da_hit),
    .clr_vec (da_clr),
    .freeze  (in_debug),
    .q       (da_sticky)
  );

  assign any_hit = (|pc_hit) || (|da_hit);
  assign dbg_exc = any_hit && !in_debug;

endmodule

// File: rtl/dbg_match_unit_chk.sv
module dbg_match_unit_chk #(
  parameter int unsigned NUM_PC = 4,
  parameter int unsigned NUM_DA = 4,
  parameter int unsigned AW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [4:0]        reg_addr,
  input logic              fetch_valid,
  input logic              mem_valid,
  input logic              in_debug,
  input logic              dbg_exc,
  input logic [NUM_PC-1:0] pc_hit,
  input logic [NUM_DA-1:0] da_hit,
  input logic [NUM_PC-1:0] pc_en_q,
  input logic [NUM_DA-1:0] da_en_q,
  input logic [NUM_PC-1:0] pc_sticky,
  input logic [NUM_DA-1:0] da_sticky
);
  logic status_touch;
  assign status_touch = reg_we && (reg_addr == 5'h03);

  p_fetch_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|pc_hit) |-> fetch_valid);

  p_pc_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_hit & ~pc_en_q) == '0);

  p_da_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (da_hit & ~da_en_q) == '0);

  p_mem_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|da_hit) |-> mem_valid);

  p_exc_on_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|pc_hit || |da_hit) && !in_debug) |-> dbg_exc);

  p_pc_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|pc_hit) && !in_debug) |=> ((pc_sticky & $past(pc_hit)) == $past(pc_hit)));

  p_da_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((|da_hit) && !in_debug) |=> ((da_sticky & $past(da_hit)) == $past(da_hit)));

  p_no_exc_dbg_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_debug |-> !dbg_exc);

  p_frozen_dbg_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_debug && !status_touch) |=> ($stable(pc_sticky) && $stable(da_sticky)));

endmodule

bind dbg_match_unit dbg_match_unit_chk #(.NUM_PC(NUM_PC), .NUM_DA(NUM_DA), .AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_we      (reg_we),
  .reg_addr    (reg_addr),
  .fetch_valid (fetch_valid),
  .mem_valid   (mem_valid),
  .in_debug    (in_debug),
  .dbg_exc     (dbg_exc),
  .pc_hit      (pc_hit),
  .da_hit      (da_hit),
  .pc_en_q     (pc_en_q),
  .da_en_q     (da_en_q),
  .pc_sticky   (pc_sticky),
  .da_sticky   (da_sticky)
);

// File: tb/dbg_match_unit_test.sv
module dbg_match_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NPC = 4;
  localparam int NDA = 4;
  localparam int AW  = 32;

  logic           clk = 0;
  logic           rst_n = 0;
  logic           reg_we = 0;
  logic [4:0]     reg_addr = '0;
  logic [31:0]    reg_wdata = '0;
  logic [31:0]    reg_rdata;
  logic           fetch_valid = 0;
  logic [AW-1:0]  fetch_pc = '0;
  logic           mem_valid = 0;
  logic           mem_is_store = 0;
  logic [AW-1:0]  mem_addr = '0;
  logic           in_debug = 0;
  logic           dbg_exc;
  logic [NPC-1:0] pc_hit;
  logic [NDA-1:0] da_hit;
  logic [NPC-1:0] pc_sticky;
  logic [NDA-1:0] da_sticky;

  int n_checks = 0;
  int n_fail   = 0;
  logic          s_exc;
  logic [NPC-1:0] s_pch;
  logic [NDA-1:0] s_dah;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_match_unit #(.NUM_PC(NPC), .NUM_DA(NDA), .AW(AW)) uut (.*);

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; #1;
    d = reg_rdata;
  endtask

  // Present one cycle of fetch/memory activity; sample combinational results
  task automatic step(logic fv, logic [AW-1:0] pc, logic mv, logic st, logic [AW-1:0] ma);
    @(negedge clk);
    fetch_valid = fv; fetch_pc = pc; mem_valid = mv; mem_is_store = st; mem_addr = ma;
    #1;
    s_exc = dbg_exc; s_pch = pc_hit; s_dah = da_hit;
    @(posedge clk); #1;
    fetch_valid = 0; mem_valid = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(5'h03, d); check("R2", "status after reset", d, 0);
    rd(5'h01, d); check("R2", "pc enable after reset", d, 0);
    rd(5'h18, d); check("R2", "cond0 after reset", d, 0);
    step(1, '0, 1, 0, '0);
    check("R2", "no exc on reset values", 32'(s_exc), 0);
  endtask

  task automatic t_cap();
    logic [31:0] d;
    rd(5'h00, d); check("R1", "capability", d, 32'h44);
  endtask

  task automatic t_pc();
    logic [31:0] d;
    wr(5'h08, 32'h1000);
    wr(5'h09, 32'h2000);
    wr(5'h01, 32'h1);
    step(1, 32'h1000, 0, 0, '0);
    check("R7", "pc exc same cycle", 32'(s_exc), 1);
    check("R3", "pc hit vector", 32'(s_pch), 1);
    rd(5'h03, d); check("R8", "status after pc hit", d, 32'h1);
    step(1, 32'h1004, 0, 0, '0);
    check("R3", "near address no exc", 32'(s_exc), 0);
    step(0, 32'h1000, 0, 0, '0);
    check("R3", "fetch invalid no hit", 32'(s_pch), 0);
    step(1, 32'h2000, 0, 0, '0);
    check("R4", "disabled comparator", 32'(s_exc), 0);
    rd(5'h03, d); check("R8", "status persists", d, 32'h1);
    wr(5'h03, 32'h1);
    rd(5'h03, d); check("R9", "status cleared", d, 0);
  endtask

  task automatic t_data();
    logic [31:0] d;
    for (int i = 0; i < NDA; i++) wr(5'(16 + i), 32'h4000);
    wr(5'h18, 32'h1); wr(5'h19, 32'h2); wr(5'h1A, 32'h3); wr(5'h1B, 32'h0);
    wr(5'h02, 32'hF);
    step(0, '0, 1, 0, 32'h4000);
    check("R6", "load hits read and rw", 32'(s_dah), 32'h5);
    check("R7", "data exc same cycle", 32'(s_exc), 1);
    step(0, '0, 1, 1, 32'h4000);
    check("R6", "store hits write and rw", 32'(s_dah), 32'h6);
    step(1, 32'h4000, 0, 0, 32'h4000);
    check("R5", "fetch does not hit data", 32'(s_dah), 0);
    check("R5", "no exc without access", 32'(s_exc), 0);
    rd(5'h03, d); check("R8", "data status bits", d, 32'h0700);
    wr(5'h03, 32'hFFFF);
  endtask

  task automatic t_multi();
    logic [31:0] d;
    step(1, 32'h1000, 1, 0, 32'h4000);
    check("R10", "one exc for many", 32'(s_exc), 1);
    check("R10", "pc and data hits", {s_dah, s_pch}, {4'h5, 4'h1});
    rd(5'h03, d); check("R10", "all bits set", d, 32'h0501);
    wr(5'h03, 32'h0100);
    rd(5'h03, d); check("R9", "partial clear", d, 32'h0401);
    // clear bit0 while comparator 0 fires in the same cycle
    @(negedge clk);
    reg_we = 1; reg_addr = 5'h03; reg_wdata = 32'h1;
    fetch_valid = 1; fetch_pc = 32'h1000;
    @(posedge clk); #1;
    reg_we = 0; fetch_valid = 0;
    rd(5'h03, d); check("R9", "set wins over clear", d, 32'h0401);
    wr(5'h03, 32'hFFFF);
  endtask

  task automatic t_debug();
    logic [31:0] d;
    in_debug = 1;
    step(1, 32'h1000, 1, 1, 32'h4000);
    check("R11", "exc suppressed in debug", 32'(s_exc), 0);
    rd(5'h03, d); check("R11", "status frozen in debug", d, 0);
    in_debug = 0;
  endtask

  task automatic t_unimpl();
    logic [31:0] d;
    wr(5'h0D, 32'h1234);
    rd(5'h0D, d); check("R12", "pc slot 5 reads zero", d, 0);
    wr(5'h1C, 32'h3);
    rd(5'h1C, d); check("R12", "cond slot 4 reads zero", d, 0);
    wr(5'h01, 32'hFF);
    rd(5'h01, d); check("R12", "enable mask width", d, 32'hF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_cap();
    t_pc();
    t_data();
    t_multi();
    t_debug();
    t_unimpl();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule